// File: doc/BRIEF.md
# TLB Reload Assist Register File

This block is the register set a software miss handler uses to refill a small translation buffer. After a translation miss, the page number that missed is latched, together with the current address-space ID. The handler then reads two walk registers. These return the addresses of the first-level and second-level page-table entries for that page, so the handler needs no shift and mask code of its own. The handler loads the page-table data it fetched into the walk-control register. It then writes the real page number. That one write assembles a complete translation entry and pushes it into the buffer slot named by the control register.

Access is through a simple request/acknowledge register bus addressed by a 3-bit register number. A separate miss strobe carries the missing virtual page number. A one-cycle entry-write strobe carries slot index, tag and data to the translation array, which lives outside this block. A write that commits an entry holds the bus off for one extra cycle, so accesses stay strictly serialized.

Top module: `tlb_reload_assist`

## Requirements
- R1: After reset, register 0 (control) reads 0x04000000 (the CTL_RST parameter default) and registers 1 to 7 all read 0. `ready_o` is 1 and `tlb_we_o` is 0.
- R2: A request is accepted on a clock edge where `req_i` and `ready_o` are both 1, and `ack_o` is 1 in the following cycle. For a read, `rdata_o` carries the value in that cycle. Writes keep only the defined bits: control 0xFE001F00 (slot index in bits 12:8, walk-assist enable at bit 26), miss page 0xFFFFF20F (page 31:12, valid 9, ID 3:0), table base 0xFFFFF000, walk control 0xFFFFF1FF, current ID 0x0000000F, real page and scratch all 32 bits. Register 7 reads 0 and ignores writes.
- R3: A `miss_i` pulse loads the miss-page register (1) with `miss_vpn_i` in bits 31:12, valid bit 9 set, and the current ID (register 5) in bits 3:0. When a bus write to register 1 lands on the same edge, the miss value wins.
- R4: With walk assist on, reading register 2 returns table base bits 31:12, then miss-page bits 31:22 in bits 11:2, then 00.
- R5: With walk assist on, reading register 3 returns the second-level base (bits 31:12) plus four times miss-page bits 21:12.
- R6: With walk assist off (control bit 26 = 0), registers 2 and 3 read back their raw stored values.
- R7: A write to register 4 raises `tlb_we_o` for exactly the next cycle. `tlb_idx_o` is control bits 12:8. `tlb_tag_o` is miss-page bits 31:12, bit 9 and bits 3:0, with all other bits 0. `tlb_data_o` is written bits 31:9 over walk-control bits 8:0 (protection group 8:5, guarded 4, size 3:2, write-through 1, segment valid 0).
- R8: The page-size field (walk-control bits 3:2) masks page-number bits in both tag and data. For 11 (8 MB), bits 22:12 are cleared. For 01 (512 KB), bits 18:12 are cleared. For 00 and 10, nothing is cleared.
- R9: During the entry-write cycle `ready_o` is 0, and a request presented in that cycle is ignored. The commit's `ack_o` follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 3 | Register number |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Block can accept a request |
| ack_o | output | 1 | Access complete |
| rdata_o | output | 32 | Read data, valid with ack_o |
| miss_i | input | 1 | Translation miss strobe |
| miss_vpn_i | input | 20 | Virtual page number that missed |
| tlb_we_o | output | 1 | Entry write strobe |
| tlb_idx_o | output | 5 | Target slot |
| tlb_tag_o | output | 32 | Entry tag |
| tlb_data_o | output | 32 | Entry data |

## Verification
The walk reads are swept two ways. Walking-one page numbers show whether each page bit lands in the right position of the first-level and second-level addresses. A run of scattered page numbers exercises the two index fields together. All 32 slots are committed with all four page-size codes, which separates the two masking widths from the unmasked cases. Each commit uses a distinct pattern of ID, valid bit and attributes, so a swapped field shows up in the entry. Miss capture is tried alone and racing a bus write to the same register. The raw-read mode and the ignored request during a commit are each checked at the bus.

// File: rtl/tlbra_pkg.sv
package tlbra_pkg;
  localparam int unsigned DW         = 32;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned NREG       = 1 << SEL_W;
  localparam int unsigned PAGE_LSB   = 12;
  localparam int unsigned VPN_W      = DW - PAGE_LSB;
  localparam int unsigned L1_LSB     = 22;
  localparam int unsigned IDX_LSB    = 8;
  localparam int unsigned ASSIST_BIT = 26;
  localparam int unsigned VALID_BIT  = 9;
  localparam int unsigned ATTR_W     = 9;
  localparam int unsigned RPN_W      = DW - ATTR_W;
  localparam int unsigned PS_LSB     = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTL, SEL_MISS, SEL_TBASE, SEL_WALK, SEL_RPAGE, SEL_CURID, SEL_SCR, SEL_NONE
  } reg_sel_e;

  function automatic logic [DW-1:0] reg_wmask(int unsigned i, int unsigned asid_w);
    case (i)
      0:       return 32'hFE00_1F00;
      1:       return 32'hFFFF_F200 | ((32'd1 << asid_w) - 32'd1);
      2:       return 32'hFFFF_F000;
      3:       return 32'hFFFF_F1FF;
      4, 6:    return 32'hFFFF_FFFF;
      5:       return (32'd1 << asid_w) - 32'd1;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [VPN_W-1:0] size_keep(logic [1:0] ps);
    case (ps)
      2'b11:   return ~VPN_W'(20'h007FF);
      2'b01:   return ~VPN_W'(20'h0007F);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/tlbra_regs.sv
module tlbra_regs import tlbra_pkg::*; #(
  parameter int unsigned ASID_W  = 4,
  parameter logic [DW-1:0] CTL_RST = 32'h0400_0000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [SEL_W-1:0]          wsel_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic                      miss_i,
  input  logic [VPN_W-1:0]          miss_vpn_i,
  output logic [NREG-1:0][DW-1:0]   regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MASK = reg_wmask(i, ASID_W);
    localparam logic [DW-1:0] RST  = (i == 0) ? (CTL_RST & MASK) : '0;
    if (MASK == '0) begin : g_none
      assign regs_o[i] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      logic          hit;
      assign hit = wr_en_i && (wsel_i == SEL_W'(i));
      if (i == int'(SEL_MISS)) begin : g_miss
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)      q <= RST;
          else if (miss_i)  q <= {miss_vpn_i, {PAGE_LSB{1'b0}}}
                               | (DW'(1) << VALID_BIT)
                               | (regs_o[int'(SEL_CURID)] & MASK);
          else if (hit)     q <= wdata_i & MASK;
        end
      end else begin : g_plain
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)   q <= RST;
          else if (hit)  q <= wdata_i & MASK;
        end
      end
      assign regs_o[i] = q;
    end
  end

  AST_MISS_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> regs_o[int'(SEL_MISS)][DW-1:PAGE_LSB] == $past(miss_vpn_i)
               && regs_o[int'(SEL_MISS)][VALID_BIT]); // R3
endmodule

// File: rtl/tlbra_view.sv
module tlbra_view import tlbra_pkg::*; (
  input  logic [NREG-1:0][DW-1:0] regs_i,
  input  logic [SEL_W-1:0]        rsel_i,
  output logic [DW-1:0]           rd_o
);
  logic [DW-1:0] ctl, miss, tbase, walk;
  logic          assist;
  logic [DW-1:0] l1_addr, l2_addr;
  reg_sel_e      sel;

  assign ctl    = regs_i[int'(SEL_CTL)];
  assign miss   = regs_i[int'(SEL_MISS)];
  assign tbase  = regs_i[int'(SEL_TBASE)];
  assign walk   = regs_i[int'(SEL_WALK)];
  assign assist = ctl[ASSIST_BIT];
  assign sel    = reg_sel_e'(rsel_i);

  // first level: base | va[31:22] at [11:2]
  assign l1_addr = {tbase[DW-1:PAGE_LSB], miss[DW-1:L1_LSB], 2'b00};
  // second level: base + 4 * va[21:12]
  assign l2_addr = {walk[DW-1:PAGE_LSB], {PAGE_LSB{1'b0}}}
                 + DW'({miss[L1_LSB-1:PAGE_LSB], 2'b00});

  always_comb begin
    case (sel)
      SEL_TBASE: rd_o = assist ? l1_addr : tbase;
      SEL_WALK:  rd_o = assist ? l2_addr : walk;
      default:   rd_o = regs_i[rsel_i];
    endcase
  end
endmodule

// File: rtl/tlbra_commit.sv
module tlbra_commit import tlbra_pkg::*; #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned ASID_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic              valid_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [RPN_W-1:0]  rpn_i,
  output logic              tlb_we_o,
  output logic [IDX_W-1:0]  tlb_idx_o,
  output logic [DW-1:0]     tlb_tag_o,
  output logic [DW-1:0]     tlb_data_o
);
  logic [VPN_W-1:0] keep;
  logic [DW-1:0]    tag_d, data_d;

  assign keep   = size_keep(attr_i[PS_LSB +: 2]);
  assign tag_d  = {vpn_i & keep, {PAGE_LSB{1'b0}}}
                | (DW'(valid_i) << VALID_BIT) | DW'(asid_i);
  assign data_d = {rpn_i[RPN_W-1 -: VPN_W] & keep, rpn_i[RPN_W-VPN_W-1:0], attr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tlb_we_o   <= 1'b0;
      tlb_idx_o  <= '0;
      tlb_tag_o  <= '0;
      tlb_data_o <= '0;
    end else begin
      tlb_we_o <= fire_i;
      if (fire_i) begin
        tlb_idx_o  <= idx_i;
        tlb_tag_o  <= tag_d;
        tlb_data_o <= data_d;
      end
    end
  end

  AST_COMMIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_we_o |=> !tlb_we_o); // R7
  AST_BIG_PAGE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tlb_we_o && tlb_data_o[PS_LSB +: 2] == 2'b11)
      |-> (tlb_tag_o[22:PAGE_LSB] == '0 && tlb_data_o[22:PAGE_LSB] == '0)); // R8
endmodule

// File: rtl/tlb_reload_assist.sv
module tlb_reload_assist import tlbra_pkg::*; #(
  parameter int unsigned   IDX_W   = 5,
  parameter int unsigned   ASID_W  = 4,
  parameter logic [DW-1:0] CTL_RST = 32'h0400_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             ready_o,
  output logic             ack_o,
  output logic [DW-1:0]    rdata_o,
  input  logic             miss_i,
  input  logic [VPN_W-1:0] miss_vpn_i,
  output logic             tlb_we_o,
  output logic [IDX_W-1:0] tlb_idx_o,
  output logic [DW-1:0]    tlb_tag_o,
  output logic [DW-1:0]    tlb_data_o
);
  logic                    accept, wr_en, commit;
  logic                    busy_q;
  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0]           rd_val, ctl_q, miss_q, walk_q;

  assign ready_o = !busy_q;
  assign accept  = req_i && ready_o;
  assign wr_en   = accept && we_i;
  assign commit  = wr_en && (reg_sel_i == SEL_RPAGE);

  assign ctl_q  = regs[int'(SEL_CTL)];
  assign miss_q = regs[int'(SEL_MISS)];
  assign walk_q = regs[int'(SEL_WALK)];

  tlbra_regs #(.ASID_W(ASID_W), .CTL_RST(CTL_RST)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wsel_i(reg_sel_i), .wdata_i,
    .miss_i, .miss_vpn_i, .regs_o(regs)
  );

  tlbra_view u_view (.regs_i(regs), .rsel_i(reg_sel_i), .rd_o(rd_val));

  tlbra_commit #(.IDX_W(IDX_W), .ASID_W(ASID_W)) u_commit (
    .clk_i, .rst_ni, .fire_i(commit),
    .idx_i  (ctl_q[IDX_LSB +: IDX_W]),
    .vpn_i  (miss_q[DW-1:PAGE_LSB]),
    .valid_i(miss_q[VALID_BIT]),
    .asid_i (miss_q[ASID_W-1:0]),
    .attr_i (walk_q[ATTR_W-1:0]),
    .rpn_i  (wdata_i[DW-1:ATTR_W]),
    .tlb_we_o, .tlb_idx_o, .tlb_tag_o, .tlb_data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      busy_q  <= commit;
      ack_o   <= (accept && !commit) || busy_q;
      rdata_o <= (accept && !we_i) ? rd_val : '0;
    end
  end

  AST_NOT_READY_IN_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_we_o |-> !ready_o); // R9
  AST_ACK_AFTER_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_we_o |=> ack_o); // R9
  AST_IDX_FROM_CTL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_we_o |-> tlb_idx_o == ctl_q[IDX_LSB +: IDX_W]); // R7
  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !(we_i && reg_sel_i == SEL_RPAGE)) |=> ack_o); // R2
endmodule

// File: tb/tlb_reload_assist_tb.sv
module tlb_reload_assist_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [31:0] wdata_i = '0;
  logic        ready_o, ack_o;
  logic [31:0] rdata_o;
  logic        miss_i = 1'b0;
  logic [19:0] miss_vpn_i = '0;
  logic        tlb_we_o;
  logic [4:0]  tlb_idx_o;
  logic [31:0] tlb_tag_o, tlb_data_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  tlb_reload_assist u_dut (.*);

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", what, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [2:0] s, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; reg_sel_i = s; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    chk("R2 ack", 32'(ack_o), 32'd1);
    r = rdata_o;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    logic [31:0] r;
    acc(1'b1, s, d, r);
  endtask

  task automatic rd_chk(input string what, input logic [2:0] s, input logic [31:0] exp);
    logic [31:0] r;
    acc(1'b0, s, 32'h0, r);
    chk(what, r, exp);
  endtask

  task automatic miss(input logic [19:0] v);
    @(negedge clk_i);
    miss_i = 1'b1; miss_vpn_i = v;
    @(negedge clk_i);
    miss_i = 1'b0;
  endtask

  function automatic logic [19:0] keep(input logic [1:0] ps);
    if (ps == 2'b11) return 20'hFFFFF - 20'h007FF;
    if (ps == 2'b01) return 20'hFFFFF - 20'h0007F;
    return 20'hFFFFF;
  endfunction

  // commit with optional intruding scratch write during the busy cycle
  task automatic commit_chk(input logic [31:0] rp, input logic [4:0] idx,
                            input logic [31:0] etag, input logic [31:0] edat,
                            input logic intrude);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; reg_sel_i = 3'd4; wdata_i = rp;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    chk("R7 we pulse", 32'(tlb_we_o), 32'd1);
    chk("R9 ready low", 32'(ready_o), 32'd0);
    chk("R7 index", 32'(tlb_idx_o), 32'(idx));
    chk("R7/R8 tag", tlb_tag_o, etag);
    chk("R7/R8 data", tlb_data_o, edat);
    if (intrude) begin
      req_i = 1'b1; we_i = 1'b1; reg_sel_i = 3'd6; wdata_i = 32'hDEAD_BEEF;
    end
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    chk("R7 we single", 32'(tlb_we_o), 32'd0);
    chk("R9 ack after commit", 32'(ack_o), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 ready", 32'(ready_o), 32'd1);
    chk("R1 we", 32'(tlb_we_o), 32'd0);
    rd_chk("R1 ctl", 3'd0, 32'h0400_0000);
    for (int i = 1; i < 8; i++) rd_chk("R1 reg zero", 3'(i), 32'h0);

    // R2 write masks, assist off so walk regs read raw
    wr(3'd0, 32'h0);
    for (int i = 1; i < 8; i++) if (i != 4) wr(3'(i), 32'hFFFF_FFFF);
    rd_chk("R2 miss mask", 3'd1, 32'hFFFF_F20F);
    rd_chk("R2/R6 tbase raw", 3'd2, 32'hFFFF_F000);
    rd_chk("R2/R6 walk raw", 3'd3, 32'hFFFF_F1FF);
    rd_chk("R2 curid mask", 3'd5, 32'h0000_000F);
    rd_chk("R2 scratch", 3'd6, 32'hFFFF_FFFF);
    rd_chk("R2 reg7 ignores", 3'd7, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk("R2 ctl mask", 3'd0, 32'hFE00_1F00);

    // R3 miss capture sweep
    wr(3'd5, 32'h0000_000A);
    for (int k = 0; k < 40; k++) begin
      logic [19:0] v;
      v = 20'((k * 32'h9E37 + 32'h1234));
      miss(v);
      rd_chk("R3 capture", 3'd1, {v, 12'h20A});
    end
    // R3 miss beats same-edge write
    @(negedge clk_i);
    miss_i = 1'b1; miss_vpn_i = 20'h5A5A5;
    req_i = 1'b1; we_i = 1'b1; reg_sel_i = 3'd1; wdata_i = 32'h1111_1003;
    @(negedge clk_i);
    miss_i = 1'b0; req_i = 1'b0; we_i = 1'b0;
    rd_chk("R3 miss priority", 3'd1, 32'h5A5A_520A);

    // R4/R5 walk reads with assist on
    wr(3'd0, 32'h0400_0000);
    wr(3'd2, 32'hABCDE_FFF);
    wr(3'd3, 32'h12345_1F5);
    for (int k = 0; k < 60; k++) begin
      logic [19:0] v;
      v = (k < 20) ? (20'd1 << k) : 20'((k * 32'h2D1B3 + 32'h77));
      wr(3'd1, {v, 12'h0});
      rd_chk("R4 l1 addr", 3'd2, {20'hABCDE, v[19:10], 2'b00});
      rd_chk("R5 l2 addr", 3'd3, 32'h1234_5000 + 32'(v[9:0]) * 4);
    end
    // R6 assist off returns raw values
    wr(3'd0, 32'h0000_0000);
    rd_chk("R6 tbase raw", 3'd2, 32'hABCDE_000);
    rd_chk("R6 walk raw", 3'd3, 32'h12345_1F5);

    // R7/R8/R9 commits into every slot, all page sizes
    wr(3'd6, 32'h600D_F00D);
    for (int i = 0; i < 32; i++) begin
      logic [4:0]  idx;
      logic [19:0] v;
      logic [3:0]  id;
      logic        vb;
      logic [8:0]  attr;
      logic [31:0] rp, etag, edat;
      idx  = 5'(i);
      v    = 20'((i * 32'h3C5A7 + 32'hF0F0F));
      id   = idx[3:0];
      vb   = idx[0];
      attr = {idx[3:0] ^ 4'h5, idx[2], idx[1:0], idx[4], ~idx[0]};
      rp   = 32'(i) * 32'h9E37_79B1 + 32'h0000_0E00;
      wr(3'd0, 32'h0400_0000 | (32'(idx) << 8) | (idx[0] ? 32'h0800_0000 : 32'h0));
      wr(3'd1, {v, 2'b00, vb, 5'b0, id});
      wr(3'd3, {20'h00042, 3'b000, attr});
      etag = {v & keep(attr[3:2]), 2'b00, vb, 5'b0, id};
      edat = {rp[31:12] & keep(attr[3:2]), rp[11:9], attr};
      commit_chk(rp, idx, etag, edat, i == 5);
      rd_chk("R7 real page readback", 3'd4, rp);
    end
    // R9 intruding write was ignored
    rd_chk("R9 ignored request", 3'd6, 32'h600D_F00D);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule